// File: doc/BRIEF.md
# SDRAM Periodic Auto-Refresh Scheduler

This block keeps an SDRAM's contents alive by issuing all-bank auto-refresh commands at a steady average rate. It sits beside the main command arbiter. An interval timer, set from the clock frequency and the refresh period, records a refresh obligation each time it expires. The scheduler then raises a bus request to the arbiter and waits for a grant. Once it holds the bus, it closes any open bank with a precharge-all command, waits tRP, and issues the refresh. It then keeps the command pins at NOP for tRC before it lets the bus go.

Expiries that happen while the grant is withheld are counted in a bounded backlog. When the bus is finally granted, the backlog is drained as back-to-back refreshes spaced exactly tRC apart. An expiry that arrives while the backlog is full sets a sticky error flag. The refresh address is generated inside the memory, so only the control pins and address bit 10 are driven. Address bit 10 is the all-banks qualifier of the precharge command.

Top module: `sdram_refresh_sched`

## Requirements
- R1: With the bus granted at all times and all banks idle, successive refresh commands are exactly floor(CLK_KHZ*REFI_NS/1e6) cycles apart. The bench setting of 10000 kHz and 15625 ns gives 156 cycles.
- R2: `req_o` rises the cycle after an obligation is recorded. It stays high until tRC cycles after the last pending refresh and is low in the cycle exactly tRC after that refresh.
- R3: While `req_o` is high and `grant_i` is low, `drive_o` is 0 and the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0).
- R4: A refresh command is cs_n=0, ras_n=0, cas_n=0, we_n=1, with `sd_cke_o` high, and it lasts one cycle.
- R5: If any bit of `bank_open_i` is set when the grant is sampled, a precharge-all command comes first, in the next cycle. Its encoding is cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1. The refresh follows exactly TRP cycles after the precharge-all.
- R6: If all banks are idle when the grant is sampled, the refresh appears in the next cycle, with no precharge.
- R7: For TRC-1 cycles after a refresh, the pins carry only NOP. Two refreshes are never closer than TRC cycles.
- R8: Up to PEND_MAX expiries that arrive without a grant are kept. After the grant, they are serviced as refreshes exactly TRC cycles apart.
- R9: An expiry that arrives while the backlog holds PEND_MAX sets `ovf_err_o`. The flag stays set until reset.
- R10: `sd_cke_o` is always 1. `sd_a10_o` is 1 only during a precharge-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank_open_i | input | NUM_BANKS | Banks the arbiter currently tracks as open |
| grant_i | input | 1 | Bus grant from the arbiter |
| req_o | output | 1 | Bus request to the arbiter |
| drive_o | output | 1 | Scheduler owns the command pins this cycle |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_cke_o | output | 1 | Clock enable |
| sd_a10_o | output | 1 | Address bit 10, all-banks qualifier |
| ovf_err_o | output | 1 | Sticky backlog overflow flag |

## Verification
The embedded properties watch every cycle for the following:
- no precharge or refresh inside a tRC quiet window;
- the command pins are never owned without a request;
- address bit 10 is high only with a precharge encoding;
- the backlog never exceeds its bound, and the overflow flag never clears without reset;
- the request drops after the final tRC wait.

Only the bench scenarios can show the exact request-to-refresh interval and its rounding. The same goes for the precharge-to-refresh distance under different bank patterns and grant delays, the exact tRC spacing of a drained backlog, and the moment the overflow flag first rises.

// File: rtl/sdram_ref_pkg.sv
// Package: shared command encodings and scheduler state type.
// Assumes the command pins are cs_n, ras_n, cas_n, we_n plus address bit 10.
package sdram_ref_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic a10;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
    localparam sd_cmd_t CMD_PREA = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
    localparam sd_cmd_t CMD_AREF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_TRP,
        ST_REF,
        ST_TRC
    } ref_state_e;

    function automatic logic cmd_is_pre(sd_cmd_t c);
        return (c.cs_n == 1'b0) && (c.ras_n == 1'b0) && (c.cas_n == 1'b1) && (c.we_n == 1'b0);
    endfunction

    function automatic logic cmd_is_aref(sd_cmd_t c);
        return (c.cs_n == 1'b0) && (c.ras_n == 1'b0) && (c.cas_n == 1'b0) && (c.we_n == 1'b1);
    endfunction

endpackage

// File: rtl/ref_tick_timer.sv
// Module: free-running interval timer.
// Pulses tick_o for one cycle every REFI_CYC cycles, starting REFI_CYC-1
// cycles after reset is released. Assumes REFI_CYC >= 2.
module ref_tick_timer #(
    parameter int REFI_CYC = 3125
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int TW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(REFI_CYC - 1);

    logic [TW-1:0] cnt_q;

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q == LAST)  cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    // Expiry pulse in the last cycle of each interval.
    always_comb tick_o = (cnt_q == LAST);

endmodule

// File: rtl/ref_backlog.sv
// Module: bounded counter of refresh obligations.
// Adds one per timer expiry and removes one per issued refresh. An expiry
// that arrives with the counter full and no refresh issued in the same cycle
// sets a sticky overflow flag. Assumes svc_i is only asserted while pend_nz_o is high.
module ref_backlog #(
    parameter int PEND_MAX = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic svc_i,
    output logic pend_nz_o,
    output logic ovf_o
);
    localparam int PW = $clog2(PEND_MAX + 1);
    localparam logic [PW-1:0] FULL = PW'(PEND_MAX);

    logic [PW-1:0] pend_q;
    logic          ovf_q;

    // Track outstanding obligations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (tick_i && !svc_i && pend_q != FULL) begin
            pend_q <= pend_q + 1'b1;
        end else if (svc_i && !tick_i) begin
            pend_q <= pend_q - 1'b1;
        end
    end

    // Latch an overflow until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   ovf_q <= 1'b0;
        else if (tick_i && !svc_i && pend_q == FULL)  ovf_q <= 1'b1;
    end

    // Export the status flags.
    always_comb begin
        pend_nz_o = (pend_q != '0);
        ovf_o     = ovf_q;
    end

    // R8
    pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) pend_q <= FULL);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf_q |=> ovf_q);

endmodule

// File: rtl/ref_seq_fsm.sv
// Module: refresh sequencer.
// Requests the bus while work is pending, precharges all banks if any is
// open, waits tRP, issues one refresh per obligation and holds NOP for tRC.
// Assumes the arbiter keeps grant_i high while req_o is high once granted,
// and that TRP >= 2 and TRC >= 2.
module ref_seq_fsm
    import sdram_ref_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int TRP       = 3,
    parameter int TRC       = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pend_nz_i,
    input  logic                 grant_i,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    output logic                 req_o,
    output logic                 drive_o,
    output logic                 svc_o,
    output sd_cmd_t              cmd_o
);
    localparam int WMAX = (TRC > TRP) ? TRC : TRP;
    localparam int WW   = $clog2(WMAX + 1);

    ref_state_e    state_q;
    logic [WW-1:0] wcnt_q;
    logic          any_open;

    // Reduce the open-bank vector.
    always_comb any_open = |bank_open_i;

    // Advance the sequence and load the wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wcnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (pend_nz_i) state_q <= ST_REQ;
                ST_REQ: begin
                    if (grant_i) state_q <= any_open ? ST_PRE : ST_REF;
                end
                ST_PRE: begin
                    state_q <= ST_TRP;
                    wcnt_q  <= WW'(TRP - 2);
                end
                ST_TRP: begin
                    if (wcnt_q == '0) state_q <= ST_REF;
                    else              wcnt_q  <= wcnt_q - 1'b1;
                end
                ST_REF: begin
                    state_q <= ST_TRC;
                    wcnt_q  <= WW'(TRC - 2);
                end
                ST_TRC: begin
                    if (wcnt_q != '0)   wcnt_q  <= wcnt_q - 1'b1;
                    else if (!pend_nz_i) state_q <= ST_IDLE;
                    else if (grant_i)    state_q <= ST_REF;
                    else                 state_q <= ST_REQ;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decode outputs from the current state.
    always_comb begin
        req_o   = (state_q != ST_IDLE);
        drive_o = (state_q == ST_PRE) || (state_q == ST_TRP) ||
                  (state_q == ST_REF) || (state_q == ST_TRC);
        svc_o   = (state_q == ST_REF);
        cmd_o   = CMD_NOP;
        if (state_q == ST_PRE) cmd_o = CMD_PREA;
        if (state_q == ST_REF) cmd_o = CMD_AREF;
    end

    // R2
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRC && wcnt_q == '0 && !pend_nz_i) |=> !req_o);

    // R5
    pre_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && grant_i && any_open) |=> (cmd_is_pre(cmd_o) && cmd_o.a10));

    // R6
    idle_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REQ && grant_i && !any_open) |=> cmd_is_aref(cmd_o));

endmodule

// File: rtl/sdram_refresh_sched.sv
// Module: top of the auto-refresh scheduler.
// Derives the refresh interval from CLK_KHZ and REFI_NS, rounding down to
// whole cycles, and wires the timer, backlog and sequencer to the pins.
// Assumes the arbiter muxes these pins onto the device only while drive_o is high.
module sdram_refresh_sched
    import sdram_ref_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CLK_KHZ   = 200000,
    parameter int REFI_NS   = 15625,
    parameter int TRP       = 3,
    parameter int TRC       = 7,
    parameter int PEND_MAX  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_open_i,
    input  logic                 grant_i,
    output logic                 req_o,
    output logic                 drive_o,
    output logic                 sd_cs_n_o,
    output logic                 sd_ras_n_o,
    output logic                 sd_cas_n_o,
    output logic                 sd_we_n_o,
    output logic                 sd_cke_o,
    output logic                 sd_a10_o,
    output logic                 ovf_err_o
);
    localparam longint unsigned REFI_L   = (64'(CLK_KHZ) * 64'(REFI_NS)) / 64'd1000000;
    localparam int              REFI_CYC = int'(REFI_L);
    localparam int              QW       = $clog2(TRC + 1);

    logic    tick;
    logic    svc;
    logic    pend_nz;
    sd_cmd_t cmd;

    ref_tick_timer #(.REFI_CYC(REFI_CYC)) timer_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    ref_backlog #(.PEND_MAX(PEND_MAX)) backlog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .svc_i     (svc),
        .pend_nz_o (pend_nz),
        .ovf_o     (ovf_err_o)
    );

    ref_seq_fsm #(.NUM_BANKS(NUM_BANKS), .TRP(TRP), .TRC(TRC)) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_nz_i   (pend_nz),
        .grant_i     (grant_i),
        .bank_open_i (bank_open_i),
        .req_o       (req_o),
        .drive_o     (drive_o),
        .svc_o       (svc),
        .cmd_o       (cmd)
    );

    // Put the command on the pins, with the clock enable held high.
    always_comb begin
        sd_cs_n_o  = cmd.cs_n;
        sd_ras_n_o = cmd.ras_n;
        sd_cas_n_o = cmd.cas_n;
        sd_we_n_o  = cmd.we_n;
        sd_a10_o   = cmd.a10;
        sd_cke_o   = 1'b1;
    end

    // Cycles since the last refresh on the pins, saturating at TRC (checking only).
    logic [QW-1:0] since_ref_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                     since_ref_q <= QW'(TRC);
        else if (cmd_is_aref(cmd))      since_ref_q <= '0;
        else if (since_ref_q < QW'(TRC)) since_ref_q <= since_ref_q + 1'b1;
    end

    // R7
    trc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_ref_q < QW'(TRC - 1)) |-> !(cmd_is_aref(cmd) || cmd_is_pre(cmd)));

    // R3
    own_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_o |-> req_o);

    // R10
    a10_pre_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sd_cke_o && (!sd_a10_o || (!sd_ras_n_o && sd_cas_n_o && !sd_we_n_o))));

endmodule

// File: tb/sdram_refresh_sched_tb_top.sv
module sdram_refresh_sched_tb_top;

    localparam int NB       = 4;
    localparam int TRP      = 3;
    localparam int TRC      = 7;
    localparam int PMAX     = 8;
    localparam int REFI     = 156;   // floor(10000 kHz * 15625 ns / 1e6)
    localparam logic [4:0] E_NOP = 5'b01110;
    localparam logic [4:0] E_PRE = 5'b00101;
    localparam logic [4:0] E_REF = 5'b00010;

    typedef struct packed {
        logic [3:0] banks;
        logic [7:0] gdly;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{banks: 4'b0000, gdly: 8'd0},
        '{banks: 4'b0001, gdly: 8'd3},
        '{banks: 4'b1000, gdly: 8'd0},
        '{banks: 4'b0000, gdly: 8'd5},
        '{banks: 4'b1111, gdly: 8'd1},
        '{banks: 4'b0100, gdly: 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NB-1:0] bank_open;
    logic          grant;
    logic          req, drive, cs_n, ras_n, cas_n, we_n, cke, a10, ovf;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sdram_refresh_sched #(
        .NUM_BANKS(NB), .CLK_KHZ(10000), .REFI_NS(15625),
        .TRP(TRP), .TRC(TRC), .PEND_MAX(PMAX)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .bank_open_i(bank_open), .grant_i(grant),
        .req_o(req), .drive_o(drive), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n),
        .sd_cas_n_o(cas_n), .sd_we_n_o(we_n), .sd_cke_o(cke), .sd_a10_o(a10),
        .ovf_err_o(ovf)
    );

    wire [4:0] pins = {cs_n, ras_n, cas_n, we_n, a10};

    task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req_tag, act, exp, cyc);
        end
    endtask

    // Wait for the next refresh on the pins; return its cycle number.
    task automatic wait_ref(output int at);
        at = -1;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (pins[4:1] == E_REF[4:1]) begin at = cyc; break; end
        end
    endtask

    task automatic wait_req_rise;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (req) break;
        end
    endtask

    // Monitor: refresh spacing and the quiet window after each refresh (R7).
    int last_ref = -1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (pins[4:1] == E_REF[4:1]) begin
                if (last_ref >= 0) chk("R7 spacing>=TRC", 32'(cyc - last_ref >= TRC), 1);
                last_ref = cyc;
            end else if (pins[4:1] == E_PRE[4:1] && last_ref >= 0 && cyc - last_ref < TRC) begin
                chk("R7 precharge in tRC window", 0, 1);
            end
        end
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int t0, t1;
        rst_n = 1'b0; grant = 1'b0; bank_open = '0;
        repeat (3) @(negedge clk);
        // Reset state (R2, R3, R9, R10).
        chk("R2 reset req", 32'(req), 0);
        chk("R3 reset drive", 32'(drive), 0);
        chk("R3 reset pins NOP", 32'(pins), 32'(E_NOP));
        chk("R9 reset ovf", 32'(ovf), 0);
        chk("R10 reset cke", 32'(cke), 1);
        rst_n = 1'b1;

        // Vector table: bank pattern and grant delay per refresh.
        foreach (VECS[i]) begin
            wait_req_rise();
            bank_open = VECS[i].banks;
            for (int d = 0; d < int'(VECS[i].gdly); d++) @(negedge clk);
            chk("R3 no drive before grant", 32'(drive), 0);
            chk("R3 NOP before grant", 32'(pins), 32'(E_NOP));
            grant = 1'b1;
            @(negedge clk);
            if (|VECS[i].banks) begin
                chk("R5 precharge-all first", 32'(pins), 32'(E_PRE));
                bank_open = '0;
                repeat (TRP) @(negedge clk);
                chk("R5 refresh TRP after precharge", 32'(pins), 32'(E_REF));
            end else begin
                chk("R6 refresh right after grant", 32'(pins), 32'(E_REF));
            end
            chk("R4 cke during refresh", 32'(cke), 1);
            chk("R10 a10 low on refresh", 32'(a10), 0);
            repeat (TRC - 1) @(negedge clk);
            chk("R2 req held through tRC", 32'(req), 1);
            chk("R7 NOP at end of tRC", 32'(pins), 32'(E_NOP));
            @(negedge clk);
            chk("R2 req dropped after tRC", 32'(req), 0);
            grant = 1'b0;
        end

        // R1: steady grant, banks idle, consecutive refreshes REFI apart.
        grant = 1'b1;
        wait_ref(t0);
        wait_ref(t0);
        wait_ref(t1);
        chk("R1 refresh interval", 32'(t1 - t0), REFI);
        @(negedge clk);
        chk("R4 refresh lasts one cycle", 32'(pins), 32'(E_NOP));
        repeat (TRC) @(negedge clk);
        grant = 1'b0;

        // R8/R9: fill the backlog without a grant, then overflow it.
        wait_req_rise();
        repeat (7 * REFI) @(negedge clk);
        chk("R9 no overflow at PEND_MAX", 32'(ovf), 0);
        chk("R3 idle while ungranted", 32'(drive), 0);
        repeat (REFI) @(negedge clk);
        chk("R9 overflow on extra expiry", 32'(ovf), 1);
        grant = 1'b1;
        wait_ref(t0);
        for (int k = 1; k < PMAX; k++) begin
            wait_ref(t1);
            chk("R8 backlog spacing TRC", 32'(t1 - t0), TRC);
            t0 = t1;
        end
        chk("R9 overflow sticky", 32'(ovf), 1);
        grant = 1'b0;

        // Reset clears the sticky flag.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 reset clears ovf", 32'(ovf), 0);
        chk("R2 reset clears req", 32'(req), 0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule